// File: doc/BRIEF.md
# Self-Rewriting Descriptor Ring DMA Channel

This block is a single DMA channel that walks a chain of descriptors held in memory. Each descriptor is four 32-bit words at a 16-byte aligned address: link to the next descriptor, source address, target address and command. The channel fetches a descriptor, waits for the peripheral to request service, moves the requested number of words one at a time, and then follows the link.

Its intended use is a two-entry ring in which the peripheral sets the parameters of its own transfer. A fixed header descriptor has a 16-byte count. Its source is the peripheral's descriptor port, and its target is the address of the second descriptor. Running it copies four words from the device over the whole second descriptor. The channel then reads that second descriptor back from memory, so it sees the rewritten values. It executes it to move the payload from the device's data port into the buffer the device named. The link the device supplied leads back to the header, where the channel waits for the next request.

The memory side is a plain word-wide master with a request/acknowledge handshake. A level control input starts the channel and asks it to stop. Status outputs report busy, a one-cycle done pulse after a stop, and a sticky error.

Top module: `smd_dma`

## Requirements
- R1: After a start, the channel reads a descriptor as four reads at D, D+4, D+8 and D+12, taken in order as link, source, target and command. These four reads come before any data word moves. Each memory request holds its address, direction and write data steady until `mem_ack_i`.
- R2: The command word uses bits [15:0] for the byte count, of which count/4 words move and bits [1:0] are ignored. Bit 16 makes the source address advance by 4 per word. Bit 17 does the same for the target address. A side with its bit clear stays on one address for the whole transfer, as a peripheral port does.
- R3: Each word is moved as a read from the source address followed by a write of that same value to the target address.
- R4: After a descriptor with a nonzero count is loaded, no data read begins until `dreq_i` is high. While the request stays low, memory is left untouched.
- R5: The next descriptor is read from memory only after the current transfer has ended. A header descriptor that writes 16 bytes from the device's descriptor port over the second descriptor therefore makes the channel run the device-supplied source, target and count.
- R6: When the payload transfer ends, the channel follows the link, which points back to the header. It fetches the header again and waits for the next request.
- R7: A descriptor whose count is below 4 bytes makes no data access and does not wait for `dreq_i`. The channel goes straight on to its link.
- R8: Dropping `run_i` takes effect only at a descriptor boundary, before the next fetch. The channel then goes idle with `busy_o` low and pulses `done_o` for exactly one cycle.
- R9: A start address or link that is not 16-byte aligned sets `err_o` and halts the channel. `err_o` stays high and no memory request is issued until reset.
- R10: While `rst_n` is low, `busy_o`, `done_o`, `err_o` and `mem_req_o` are all low. Raising `run_i` while idle starts a fetch at `head_addr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run_i | input | 1 | High to run; low requests a stop at the next descriptor boundary |
| head_addr_i | input | AW | Address of the first (header) descriptor |
| dreq_i | input | 1 | Peripheral request for service |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | AW | Byte address of the access |
| mem_wdata_o | output | 32 | Write data |
| mem_ack_i | input | 1 | Access accepted; read data valid in this cycle |
| mem_rdata_i | input | 32 | Read data |
| busy_o | output | 1 | Channel is running |
| done_o | output | 1 | One-cycle pulse when a stop has been honoured |
| err_o | output | 1 | Sticky alignment error |

## Verification
The bench holds the device's request low after the header has been loaded. A channel that ignored the request line would then change the second descriptor or pop the device's ports too early. Comparing the rewritten descriptor with the payload that follows shows whether the channel re-reads the descriptor after the header has written it. A cached copy would send data to the stale sentinel target instead. A memory-to-memory copy with both increment bits set, followed by a zero-length entry, exposes swapped increment bits, an extra beat, and a channel that hangs waiting for a request that a zero-length entry does not need. The stop and misalignment cases catch a stop taken mid-descriptor, a done pulse that lasts longer than one cycle, and an error flag that clears or lets the channel keep fetching.

// File: rtl/smd_pkg.sv
// Shared definitions for the self-rewriting descriptor DMA channel.
// Assumes 32-bit words and four-word descriptors at 16-byte alignment.
package smd_pkg;
    localparam int WORD_W    = 32;
    localparam int LEN_W     = 16;   // command byte count field [15:0]
    localparam int INC_SRC_B = 16;   // command bit: advance source
    localparam int INC_TGT_B = 17;   // command bit: advance target
    localparam int CNT_W     = LEN_W - 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_FETCH,
        ST_LOAD,
        ST_WAIT,
        ST_RD,
        ST_WR,
        ST_HALT
    } smd_state_e;
endpackage

// File: rtl/smd_desc_regs.sv
// Holds the fields of the descriptor being executed.
// Captures one word per accepted fetch read; idx selects the field
// (0 link, 1 source, 2 target, 3 command). Only used command bits kept.
module smd_desc_regs
    import smd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        idx,
    input  logic [WORD_W-1:0] wdata,
    output logic [AW-1:0]     link,
    output logic [AW-1:0]     src,
    output logic [AW-1:0]     tgt,
    output logic [CNT_W-1:0]  words,
    output logic              inc_src,
    output logic              inc_tgt
);
    // Field capture: store the fetched word into the field it belongs to.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            link    <= '0;
            src     <= '0;
            tgt     <= '0;
            words   <= '0;
            inc_src <= 1'b0;
            inc_tgt <= 1'b0;
        end else if (wr_en) begin
            case (idx)
                2'd0: link <= wdata[AW-1:0];
                2'd1: src  <= wdata[AW-1:0];
                2'd2: tgt  <= wdata[AW-1:0];
                default: begin
                    words   <= wdata[LEN_W-1:2];
                    inc_src <= wdata[INC_SRC_B];
                    inc_tgt <= wdata[INC_TGT_B];
                end
            endcase
        end
    end
endmodule

// File: rtl/smd_ptr.sv
// Address pointer for one side of a transfer.
// Loads a start address, then advances by one word per step when inc is set;
// with inc clear it stays put (peripheral port behaviour).
module smd_ptr #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    input  logic          inc,
    output logic [AW-1:0] addr
);
    localparam logic [AW-1:0] STRIDE = AW'(4);

    // Pointer update: load wins, otherwise optional word increment.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr <= '0;
        else if (load)
            addr <= load_val;
        else if (step && inc)
            addr <= addr + STRIDE;
    end
endmodule

// File: rtl/smd_word_cnt.sv
// Remaining-word counter for a payload transfer.
// Assumes dec is only raised while the count is nonzero.
module smd_word_cnt #(
    parameter int CW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    // Count register: reload per descriptor, minus one per written word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec)
            cnt_q <= cnt_q - CW'(1);
    end

    assign last = (cnt_q == CW'(1));
endmodule

// File: rtl/smd_dma.sv
// Single-channel descriptor-walking DMA.
// Fetches a four-word descriptor, waits for the peripheral request, moves
// count/4 words (read then write), then follows the link. The next
// descriptor is always re-read from memory, so a previous transfer may
// rewrite it. Stop and alignment checks happen only at descriptor
// boundaries. Assumes a memory that returns read data with mem_ack_i.
module smd_dma
    import smd_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic [AW-1:0]     head_addr_i,
    input  logic              dreq_i,
    output logic              mem_req_o,
    output logic              mem_we_o,
    output logic [AW-1:0]     mem_addr_o,
    output logic [WORD_W-1:0] mem_wdata_o,
    input  logic              mem_ack_i,
    input  logic [WORD_W-1:0] mem_rdata_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);
    smd_state_e        state_q;
    logic [AW-1:0]     next_q;
    logic [AW-1:0]     cur_q;
    logic [1:0]        idx_q;
    logic [WORD_W-1:0] data_q;
    logic              done_q;
    logic              err_q;

    logic [AW-1:0]     d_link, d_src, d_tgt, src_addr, tgt_addr;
    logic [CNT_W-1:0]  d_words;
    logic              d_inc_src, d_inc_tgt, cnt_last;
    logic              fetch_acc, load_go, beat_done;

    assign fetch_acc = (state_q == ST_FETCH) && mem_ack_i;
    assign load_go   = (state_q == ST_LOAD);
    assign beat_done = (state_q == ST_WR) && mem_ack_i;

    smd_desc_regs #(.AW(AW)) u_desc (
        .clk(clk), .rst_n(rst_n), .wr_en(fetch_acc), .idx(idx_q),
        .wdata(mem_rdata_i), .link(d_link), .src(d_src), .tgt(d_tgt),
        .words(d_words), .inc_src(d_inc_src), .inc_tgt(d_inc_tgt)
    );

    smd_ptr #(.AW(AW)) u_src_ptr (
        .clk(clk), .rst_n(rst_n), .load(load_go), .load_val(d_src),
        .step(beat_done), .inc(d_inc_src), .addr(src_addr)
    );

    smd_ptr #(.AW(AW)) u_tgt_ptr (
        .clk(clk), .rst_n(rst_n), .load(load_go), .load_val(d_tgt),
        .step(beat_done), .inc(d_inc_tgt), .addr(tgt_addr)
    );

    smd_word_cnt #(.CW(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(load_go), .load_val(d_words),
        .dec(beat_done), .last(cnt_last)
    );

    // Channel sequencer: boundary checks, fetch, request wait, word moves.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            next_q  <= '0;
            cur_q   <= '0;
            idx_q   <= '0;
            data_q  <= '0;
            done_q  <= 1'b0;
            err_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: if (run_i) begin
                    next_q  <= head_addr_i;
                    state_q <= ST_CHECK;
                end
                ST_CHECK: begin
                    if (!run_i) begin
                        done_q  <= 1'b1;
                        state_q <= ST_IDLE;
                    end else if (next_q[3:0] != 4'd0) begin
                        err_q   <= 1'b1;
                        state_q <= ST_HALT;
                    end else begin
                        cur_q   <= next_q;
                        idx_q   <= 2'd0;
                        state_q <= ST_FETCH;
                    end
                end
                ST_FETCH: if (mem_ack_i) begin
                    idx_q <= idx_q + 2'd1;
                    if (idx_q == 2'd3)
                        state_q <= ST_LOAD;
                end
                ST_LOAD: begin
                    next_q  <= d_link;
                    state_q <= (d_words == '0) ? ST_CHECK : ST_WAIT;
                end
                ST_WAIT: if (dreq_i)
                    state_q <= ST_RD;
                ST_RD: if (mem_ack_i) begin
                    data_q  <= mem_rdata_i;
                    state_q <= ST_WR;
                end
                ST_WR: if (mem_ack_i)
                    state_q <= cnt_last ? ST_CHECK : ST_RD;
                default: state_q <= ST_HALT;
            endcase
        end
    end

    // Memory master drive: one access per state that needs the bus.
    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        case (state_q)
            ST_FETCH: begin
                mem_req_o  = 1'b1;
                mem_addr_o = {cur_q[AW-1:4], idx_q, 2'b00};
            end
            ST_RD: begin
                mem_req_o  = 1'b1;
                mem_addr_o = src_addr;
            end
            ST_WR: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = tgt_addr;
                mem_wdata_o = data_q;
            end
            default: ;
        endcase
    end

    assign busy_o = (state_q != ST_IDLE) && (state_q != ST_HALT);
    assign done_o = done_q;
    assign err_o  = err_q;
endmodule

// File: rtl/smd_dma_chk.sv
// Port-level protocol checks for smd_dma, attached with bind below.
module smd_dma_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mem_req_o,
    input logic          mem_we_o,
    input logic [AW-1:0] mem_addr_o,
    input logic [31:0]   mem_wdata_o,
    input logic          mem_ack_i,
    input logic          busy_o,
    input logic          done_o,
    input logic          err_o
);
    // R1: a pending request keeps address and direction steady
    a_r1_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));

    // R3: write data does not change while a write waits
    a_r3_wdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && !mem_ack_i) |=> $stable(mem_wdata_o));

    // R8: done is a single-cycle pulse
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: done only when the channel reports idle
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !mem_req_o));

    // R9: error flag is sticky
    a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> err_o);

    // R9: halted channel issues no memory request
    a_r9_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (!mem_req_o && !busy_o));
endmodule

bind smd_dma smd_dma_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_ack_i(mem_ack_i),
    .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/smd_dma_bench.sv
// Directed bench: memory model with device ports, one task per scenario.
module smd_dma_bench;
    localparam logic [31:0] PDESC = 32'h8000_0000;
    localparam logic [31:0] PDATA = 32'h8000_0010;
    localparam logic [31:0] HEAD  = 32'h0000_0100;
    localparam logic [31:0] D2    = 32'h0000_0200;
    localparam logic [31:0] SENT  = 32'hAAAA_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [31:0] head_addr = HEAD;
    logic        dreq;
    logic        mem_req, mem_we, mem_ack, busy, done, err;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic [31:0] mem [0:255];
    logic [31:0] dfifo [0:31];
    logic [31:0] pfifo [0:63];
    int dwr = 0, drd = 0, pwr = 0, prd = 0;
    logic        periph_on = 1'b0;
    logic        stall_en = 1'b0;
    logic        cyc = 1'b0;
    logic [31:0] rd_log [0:7];
    int          rd_n = 0;
    logic [31:0] last_mem_rd = '0;
    int          done_cnt = 0, req_cyc = 0;
    int          errors = 0, checks = 0;
    logic        finished = 1'b0;

    always #2.5 clk = ~clk;

    smd_dma #(.AW(32)) u_smd_dma (
        .clk(clk), .rst_n(rst_n), .run_i(run), .head_addr_i(head_addr),
        .dreq_i(dreq), .mem_req_o(mem_req), .mem_we_o(mem_we),
        .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack),
        .mem_rdata_i(mem_rdata), .busy_o(busy), .done_o(done), .err_o(err)
    );

    assign mem_ack = mem_req && !(stall_en && cyc);
    assign dreq = periph_on && ((dwr != drd) || (pwr != prd));

    always_comb begin
        if (mem_addr == PDESC)      mem_rdata = dfifo[drd % 32];
        else if (mem_addr == PDATA) mem_rdata = pfifo[prd % 64];
        else                        mem_rdata = mem[mem_addr[9:2]];
    end

    // Memory and device port model
    always @(posedge clk) begin
        cyc <= ~cyc;
        if (mem_req && mem_ack) begin
            if (mem_we) begin
                if (mem_addr[31:10] == 22'd0) mem[mem_addr[9:2]] <= mem_wdata;
            end else if (mem_addr == PDESC) begin
                drd <= drd + 1;
            end else if (mem_addr == PDATA) begin
                prd <= prd + 1;
            end else begin
                last_mem_rd <= mem_addr;
                if (rd_n < 8) rd_log[rd_n] <= mem_addr;
                rd_n <= rd_n + 1;
            end
        end
    end

    // Output monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (rst_n && done) done_cnt <= done_cnt + 1;
        if (rst_n && mem_req) req_cyc <= req_cyc + 1;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic push_msg(input logic [31:0] src, input logic [31:0] tgt,
                            input logic [31:0] cmd, input int nw, input logic [31:0] seed);
        dfifo[dwr % 32] = HEAD; dwr++;
        dfifo[dwr % 32] = src;  dwr++;
        dfifo[dwr % 32] = tgt;  dwr++;
        dfifo[dwr % 32] = cmd;  dwr++;
        for (int i = 0; i < nw; i++) begin
            pfifo[pwr % 64] = seed + i;
            pwr++;
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) mem[i] = 32'h5555_0000 + i;
        mem[HEAD[9:2]]     = D2;
        mem[HEAD[9:2] + 1] = PDESC;
        mem[HEAD[9:2] + 2] = D2;
        mem[HEAD[9:2] + 3] = 32'h0002_0010;
        for (int i = 0; i < 4; i++) mem[D2[9:2] + i] = SENT + i;
        wait_cyc(4);
        chk_eq("R10 busy in reset", {31'd0, busy}, 32'd0);
        chk_eq("R10 done/err in reset", {30'd0, done, err}, 32'd0);
        chk_eq("R10 mem_req in reset", {31'd0, mem_req}, 32'd0);
        rst_n = 1'b1;
        wait_cyc(2);
    endtask

    task automatic t_first_msg();
        push_msg(PDATA, 32'h300, 32'h0002_000C, 3, 32'h1000_0000);
        run = 1'b1;
        wait_cyc(40);
        chk_eq("R10 busy after start", {31'd0, busy}, 32'd1);
        chk_eq("R1 fetch count before data", rd_n, 32'd4);
        for (int i = 0; i < 4; i++)
            chk_eq("R1 fetch address order", rd_log[i], HEAD + 32'(4 * i));
        chk_eq("R4 no port pop without request", drd + prd, 32'd0);
        chk_eq("R4 second descriptor untouched", mem[D2[9:2] + 2], SENT + 2);
        periph_on = 1'b1;
        wait_cyc(200);
        chk_eq("R5 link rewritten", mem[D2[9:2]], HEAD);
        chk_eq("R5 source rewritten", mem[D2[9:2] + 1], PDATA);
        chk_eq("R5 target rewritten", mem[D2[9:2] + 2], 32'h300);
        chk_eq("R5 command rewritten", mem[D2[9:2] + 3], 32'h0002_000C);
        for (int i = 0; i < 3; i++)
            chk_eq("R3 payload word", mem[(32'h300 >> 2) + i], 32'h1000_0000 + i);
        chk_eq("R2 word past count untouched", mem[(32'h30C >> 2)], 32'h5555_0000 + (32'h30C >> 2));
        chk_eq("R2 fixed port read per word", prd, 32'd3);
        chk_eq("R6 header fetched again", last_mem_rd, HEAD + 32'hC);
        chk_eq("R6 busy waiting at header", {31'd0, busy}, 32'd1);
    endtask

    task automatic t_stalled_msg();
        stall_en = 1'b1;
        push_msg(PDATA, 32'h340, 32'h0002_0020, 8, 32'h2000_0000);
        wait_cyc(400);
        stall_en = 1'b0;
        for (int i = 0; i < 8; i++)
            chk_eq("R3 stalled payload word", mem[(32'h340 >> 2) + i], 32'h2000_0000 + i);
        chk_eq("R2 target advanced by 4 per word", mem[(32'h360 >> 2)], 32'h5555_0000 + (32'h360 >> 2));
        chk_eq("R6 header after second message", last_mem_rd, HEAD + 32'hC);
    endtask

    task automatic t_copy_then_zero();
        int pops0 = prd;
        for (int i = 0; i < 2; i++) mem[(32'h380 >> 2) + i] = 32'h3000_0000 + i;
        periph_on = 1'b0;
        push_msg(32'h380, 32'h3C0, 32'h0003_0008, 0, 32'h0);
        push_msg(PDATA, 32'h3F0, 32'h0002_0003, 0, 32'h0);
        periph_on = 1'b1;
        wait_cyc(300);
        for (int i = 0; i < 2; i++)
            chk_eq("R2 both sides increment copy", mem[(32'h3C0 >> 2) + i], 32'h3000_0000 + i);
        chk_eq("R7 zero count makes no data pop", prd, pops0);
        chk_eq("R7 zero count target untouched", mem[(32'h3F0 >> 2)], 32'h5555_0000 + (32'h3F0 >> 2));
        chk_eq("R7 zero descriptor loaded", mem[D2[9:2] + 3], 32'h0002_0003);
        chk_eq("R7 returned to header", last_mem_rd, HEAD + 32'hC);
        chk_eq("R7 still running", {31'd0, busy}, 32'd1);
    endtask

    task automatic t_stop();
        int pops0 = prd;
        periph_on = 1'b0;
        push_msg(PDATA, 32'h3E0, 32'h0002_0004, 1, 32'h4000_0000);
        wait_cyc(20);
        run = 1'b0;
        wait_cyc(30);
        chk_eq("R8 stop not taken mid-descriptor", {31'd0, busy}, 32'd1);
        chk_eq("R8 no done before boundary", done_cnt, 32'd0);
        periph_on = 1'b1;
        wait_cyc(100);
        chk_eq("R8 idle after stop", {31'd0, busy}, 32'd0);
        chk_eq("R8 one done pulse", done_cnt, 32'd1);
        chk_eq("R8 header finished before stop", mem[D2[9:2] + 2], 32'h3E0);
        chk_eq("R8 payload not started", prd, pops0);
        periph_on = 1'b0;
    endtask

    task automatic t_misalign();
        head_addr = 32'h0000_0104;
        req_cyc = 0;
        run = 1'b1;
        wait_cyc(30);
        chk_eq("R9 error set", {31'd0, err}, 32'd1);
        chk_eq("R9 halted not busy", {31'd0, busy}, 32'd0);
        chk_eq("R9 no request after error", req_cyc, 32'd0);
        run = 1'b0;
        wait_cyc(5);
        run = 1'b1;
        wait_cyc(10);
        chk_eq("R9 error sticky", {31'd0, err}, 32'd1);
        chk_eq("R9 still no request", req_cyc, 32'd0);
    endtask

    initial begin
        t_reset();
        t_first_msg();
        t_stalled_msg();
        t_copy_then_zero();
        t_stop();
        t_misalign();
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule